// File: doc/BRIEF.md
# ECC Error Capture and Status Register

This block sits beside the error checker of a SECDED-protected SDRAM path. It records the first ECC error that arrives. The record holds the upper address bits of the failing access, the 8-bit syndrome, and whether the error was correctable or not. The record is held in one 32-bit register that software reads over a simple register port. Later errors cannot overwrite the record until software clears it.

The same register carries three enables:
- a scrub-disable bit that stops the automatic write-back of corrected data;
- an enable for a bus-error request on uncorrectable errors;
- an enable for an NMI request on corrected errors.

Software acknowledges an error by writing 1 to either status bit. That write clears both status bits and re-arms capture.

Top module: `ecc_err_capture`

## Requirements
- R1: After reset, `reg_rdata` reads 0 and `nmi_req`, `buserr_req` and `scrub_req` are all 0.
- R2: A cycle with `ev_sbe`=1 and `ev_mbe`=0, while bits 1:0 are both 0, does the following from the next cycle on:
  - sets bit 0 (single-bit status);
  - loads bits 30:12 with `ev_addr[31:13]`;
  - loads bits 11:4 with `ev_syn`.
- R3: A cycle with `ev_mbe`=1, while bits 1:0 are both 0, sets bit 1 (multi-bit status) and loads the same address and syndrome fields.
- R4: When `ev_sbe` and `ev_mbe` are both 1 in the same cycle, only bit 1 is set. Bits 1:0 are never both 1.
- R5: While bit 0 or bit 1 is set, further error events leave bits 30:0 unchanged, including the other status bit. Bits 31, 3 and 2 can still change only by a register write.
- R6: A write with `reg_wdata[0]` or `reg_wdata[1]` equal to 1 clears both bits 1:0. A write with `reg_wdata[1:0]`=0 leaves them unchanged. Bits 30:4 keep their last captured values.
- R7: Every write loads bit 31 (scrub disable), bit 3 (bus-error enable) and bit 2 (NMI enable) from `reg_wdata`. Bits 30:4 are read-only.
- R8: `nmi_req` equals bit 0 AND bit 2, as a level.
- R9: `buserr_req` equals bit 1 AND bit 3, as a level.
- R10: `scrub_req` is 1 for exactly the one cycle that follows a cycle with `ev_sbe`=1, `ev_mbe`=0 and bit 31=0. This holds whether or not that event was captured.
- R11: When a clearing write meets an error event in the same cycle, the following applies:
  - if a status bit was already set, the clear wins and the event is dropped;
  - if both status bits were 0, the event is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_sbe | input | 1 | Corrected (single-bit) error seen this cycle |
| ev_mbe | input | 1 | Uncorrectable (multi-bit) error seen this cycle |
| ev_addr | input | ADDR_W | Address of the access that failed |
| ev_syn | input | 8 | Syndrome of the failing access |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read value |
| nmi_req | output | 1 | NMI request level |
| buserr_req | output | 1 | Bus-error request level |
| scrub_req | output | 1 | One-cycle request to write back corrected data |

## Verification
The following are checked by assertions on every cycle:
- the two status bits never both set (R4);
- the captured record frozen while a status bit is held (R5);
- a clearing write always emptying the status (R6);
- a scrub pulse only ever following a qualifying corrected event (R10);
- both request outputs dropping whenever their status bit is clear (R8, R9).

Other behaviour can only be shown by the bench's scenarios, which sweep every enable combination against every event kind. These are:
- the exact address slice and syndrome placement in the read value;
- the one-cycle width of the scrub pulse;
- write-0 having no effect;
- the priority between a clear and an event that arrive in the same cycle.

// File: rtl/ecc_cap_pkg.sv
package ecc_cap_pkg;
    localparam int REG_W     = 32;
    localparam int SYN_W     = 8;
    localparam int EA_W      = 19;
    localparam int BIT_SBE   = 0;
    localparam int BIT_MBE   = 1;
    localparam int BIT_NMI   = 2;
    localparam int BIT_BUS   = 3;
    localparam int SYN_LSB   = 4;
    localparam int EA_LSB    = SYN_LSB + SYN_W;
    localparam int BIT_SCRUB = EA_LSB + EA_W;

    typedef struct packed {
        logic             sbe;
        logic             mbe;
        logic [EA_W-1:0]  ea;
        logic [SYN_W-1:0] syn;
    } cap_t;

    typedef struct packed {
        logic scrub_dis;
        logic bus_en;
        logic nmi_en;
    } ctl_t;
endpackage

// File: rtl/ecc_cap_ctl.sv
module ecc_cap_ctl
    import ecc_cap_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr,
    input  ctl_t wr_val,
    output ctl_t ctl_q
);
    ctl_t ctl_d;

    always_comb begin
        ctl_d = ctl_q;
        if (wr) begin
            ctl_d = wr_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    AST_CTL_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(ctl_q)); // R7
endmodule

// File: rtl/ecc_cap_latch.sv
module ecc_cap_latch
    import ecc_cap_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_sbe,
    input  logic             ev_mbe,
    input  logic [EA_W-1:0]  ev_ea,
    input  logic [SYN_W-1:0] ev_syn,
    input  logic             clr,
    output cap_t             cap_q
);
    cap_t cap_d;
    logic held;

    assign held = cap_q.sbe | cap_q.mbe;

    always_comb begin
        cap_d = cap_q;
        if (held) begin
            if (clr) begin
                cap_d.sbe = 1'b0;
                cap_d.mbe = 1'b0;
            end
        end else if (ev_sbe | ev_mbe) begin
            cap_d.mbe = ev_mbe;
            cap_d.sbe = ev_sbe & ~ev_mbe;
            cap_d.ea  = ev_ea;
            cap_d.syn = ev_syn;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    AST_STATUS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cap_q.sbe, cap_q.mbe})); // R4
    AST_RECORD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (held && !clr) |=> $stable(cap_q)); // R5
    AST_CLEAR_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        (held && clr) |=> (!cap_q.sbe && !cap_q.mbe)); // R6
    AST_MBE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (!held && ev_mbe) |=> (cap_q.mbe && !cap_q.sbe)); // R3
    AST_SBE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (!held && ev_sbe && !ev_mbe) |=> (cap_q.sbe && cap_q.syn == $past(ev_syn))); // R2
endmodule

// File: rtl/ecc_cap_req.sv
module ecc_cap_req
    import ecc_cap_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ev_sbe,
    input  logic ev_mbe,
    input  logic st_sbe,
    input  logic st_mbe,
    input  ctl_t ctl,
    output logic nmi_req,
    output logic buserr_req,
    output logic scrub_req
);
    typedef struct packed {
        logic scrub;
    } req_t;

    req_t req_d, req_q;

    always_comb begin
        req_d       = req_q;
        req_d.scrub = ev_sbe & ~ev_mbe & ~ctl.scrub_dis;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) req_q <= '0;
        else        req_q <= req_d;
    end

    assign scrub_req  = req_q.scrub;
    assign nmi_req    = st_sbe & ctl.nmi_en;
    assign buserr_req = st_mbe & ctl.bus_en;

    AST_SCRUB_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        scrub_req |-> $past(ev_sbe && !ev_mbe && !ctl.scrub_dis)); // R10
    AST_NMI_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        !st_sbe |-> !nmi_req); // R8
    AST_BUS_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        !st_mbe |-> !buserr_req); // R9
endmodule

// File: rtl/ecc_err_capture.sv
module ecc_err_capture
    import ecc_cap_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_sbe,
    input  logic              ev_mbe,
    input  logic [ADDR_W-1:0] ev_addr,
    input  logic [SYN_W-1:0]  ev_syn,
    input  logic              reg_wr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              nmi_req,
    output logic              buserr_req,
    output logic              scrub_req
);
    localparam int EA_TOP = ADDR_W - 1;
    localparam int EA_BOT = ADDR_W - EA_W;

    ctl_t ctl_q;
    ctl_t ctl_wr;
    cap_t cap_q;
    logic clr;
    logic unused_bits;

    assign ctl_wr.scrub_dis = reg_wdata[BIT_SCRUB];
    assign ctl_wr.bus_en    = reg_wdata[BIT_BUS];
    assign ctl_wr.nmi_en    = reg_wdata[BIT_NMI];
    assign clr              = reg_wr & (reg_wdata[BIT_SBE] | reg_wdata[BIT_MBE]);
    assign unused_bits      = ^{reg_wdata[BIT_SCRUB-1:SYN_LSB], ev_addr[EA_BOT-1:0]};

    ecc_cap_ctl u_ctl (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (reg_wr),
        .wr_val (ctl_wr),
        .ctl_q  (ctl_q)
    );

    ecc_cap_latch u_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .ev_sbe (ev_sbe),
        .ev_mbe (ev_mbe),
        .ev_ea  (ev_addr[EA_TOP:EA_BOT]),
        .ev_syn (ev_syn),
        .clr    (clr),
        .cap_q  (cap_q)
    );

    ecc_cap_req u_req (
        .clk        (clk),
        .rst_n      (rst_n),
        .ev_sbe     (ev_sbe),
        .ev_mbe     (ev_mbe),
        .st_sbe     (cap_q.sbe),
        .st_mbe     (cap_q.mbe),
        .ctl        (ctl_q),
        .nmi_req    (nmi_req),
        .buserr_req (buserr_req),
        .scrub_req  (scrub_req)
    );

    always_comb begin
        reg_rdata                           = '0;
        reg_rdata[BIT_SCRUB]                = ctl_q.scrub_dis;
        reg_rdata[BIT_SCRUB-1:EA_LSB]       = cap_q.ea;
        reg_rdata[EA_LSB-1:SYN_LSB]         = cap_q.syn;
        reg_rdata[BIT_BUS]                  = ctl_q.bus_en;
        reg_rdata[BIT_NMI]                  = ctl_q.nmi_en;
        reg_rdata[BIT_MBE]                  = cap_q.mbe;
        reg_rdata[BIT_SBE]                  = cap_q.sbe;
    end
endmodule

// File: tb/tb_ecc_err_capture.sv
`timescale 1ns/1ps
module tb_ecc_err_capture;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ev_sbe = 1'b0, ev_mbe = 1'b0;
    logic [31:0] ev_addr = '0;
    logic [7:0]  ev_syn = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        nmi_req, buserr_req, scrub_req;

    int tests = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    ecc_err_capture dut (
        .clk(clk), .rst_n(rst_n), .ev_sbe(ev_sbe), .ev_mbe(ev_mbe),
        .ev_addr(ev_addr), .ev_syn(ev_syn), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .nmi_req(nmi_req),
        .buserr_req(buserr_req), .scrub_req(scrub_req)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cyc(input logic s, input logic m, input logic [31:0] a, input logic [7:0] y,
                       input logic w, input logic [31:0] wd);
        @(negedge clk);
        ev_sbe = s; ev_mbe = m; ev_addr = a; ev_syn = y; reg_wr = w; reg_wdata = wd;
        @(negedge clk);
        ev_sbe = 0; ev_mbe = 0; reg_wr = 0; reg_wdata = '0;
    endtask

    function automatic logic [31:0] ctlw(input int cfg);
        return {cfg[2], 19'b0, 8'b0, cfg[1], cfg[0], 2'b00};
    endfunction

    initial begin
        #(5.0 * 150000);
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [31:0] exp, a, a2;
        logic [7:0] y;
        logic s, m;
        repeat (3) @(negedge clk);
        chk("R1 rdata", reg_rdata, 0);
        chk("R1 outs", {29'b0, nmi_req, buserr_req, scrub_req}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 rdata after release", reg_rdata, 0);

        for (int cfg = 0; cfg < 8; cfg++) begin
            for (int kind = 0; kind < 3; kind++) begin
                cyc(0, 0, 0, 0, 1, ctlw(cfg) | 32'h3);
                chk("R7 ctl readback", reg_rdata & 32'h8000_000F, ctlw(cfg));
                s = (kind == 0 || kind == 2);
                m = (kind >= 1);
                a = 32'h9E37_79B9 * (cfg * 3 + kind + 1);
                y = 8'(cfg * 37 + kind * 11 + 5);
                cyc(s, m, a, y, 0, 0);
                exp = ctlw(cfg) | {1'b0, a[31:13], y, 4'b0} | (m ? 32'h2 : 32'h1);
                chk(m ? (s ? "R4 both events" : "R3 mbe capture") : "R2 sbe capture", reg_rdata, exp);
                chk("R8 nmi", {31'b0, nmi_req}, {31'b0, !m && cfg[0]});
                chk("R9 buserr", {31'b0, buserr_req}, {31'b0, m && cfg[1]});
                chk("R10 scrub pulse", {31'b0, scrub_req}, {31'b0, !m && !cfg[2]});
                @(negedge clk);
                chk("R10 scrub one cycle", {31'b0, scrub_req}, 0);
                a2 = ~a;
                cyc(m, !m, a2, ~y, 0, 0);
                chk("R5 later event ignored", reg_rdata, exp);
                chk("R10 scrub uncaptured", {31'b0, scrub_req}, {31'b0, m && !cfg[2]});
                cyc(0, 0, 0, 0, 1, ctlw(cfg));
                chk("R6 write zero keeps", reg_rdata, exp);
                cyc(0, 0, 0, 0, 1, ctlw(cfg) | ((kind == 1) ? 32'h2 : 32'h1));
                chk("R6 single clear", reg_rdata, exp & ~32'h3);
                chk("R8 R9 drop", {30'b0, nmi_req, buserr_req}, 0);
                cyc(0, 0, 0, 0, 1, 32'h7FFF_FFF0 | ctlw(cfg));
                chk("R7 ro fields", reg_rdata, exp & ~32'h3);
            end
        end

        cyc(0, 0, 0, 0, 1, 32'h3);
        cyc(1, 0, 32'hA000_0000, 8'h11, 0, 0);
        cyc(0, 1, 32'h5000_0000, 8'h22, 1, 32'h1);
        chk("R11 clear beats event", reg_rdata, {1'b0, 19'h50000, 8'h11, 4'b0});
        cyc(0, 1, 32'h5000_2000, 8'h22, 1, 32'h2);
        chk("R11 event when clear", reg_rdata, {1'b0, 19'h28001, 8'h22, 4'b0010});

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule